// File: doc/BRIEF.md
# I2C Bus Master with FIFO Status Reporting

This block is a single-master I2C controller. A host reaches it through a small register port with four locations: target address, data, read length and status. The host loads outgoing bytes into a 4-entry transmit queue. It then writes the target address byte, which starts a transfer. The block produces START, the address frame, the data frames with their acknowledge clocks, and STOP, on open-drain clock and data lines. Each line is driven low only through an enable output. Incoming bytes collect in a 4-entry receive queue, and the host pops them from the data location.

The status byte gives the host the following. It shows a busy bit and a sticky no-acknowledge flag. It shows two interrupt-style levels: one for receive data waiting, one for the transmit queue being empty. It shows a 2-bit fill code for the queue of the direction in use, and two sticky error flags. If the host writes the address location while a transfer is running, the next transfer is chained behind the current one with a repeated START instead of a STOP. The SCL period is four quarter phases, and each phase lasts a parameterised number of clock cycles.

Top module: `i2c_fifo_master`

## Requirements
- R1: Bit 0 of a byte written to location 0 picks the direction (1 read, 0 write), and bits 7:1 are the 7-bit target address. After START the block sends this byte MSB first, followed by a 9th clock on which the target acknowledges.
- R2: In a write transfer, queued bytes are sent MSB first in the order they were written to location 1. When the transmit queue is empty after an acknowledged byte, the transfer ends with STOP.
- R3: A read transfer takes N bytes, where N is the value in location 2 and a value of 0 counts as 1. The block drives ACK after each byte except the last, drives NACK after the last, then sends STOP. The bytes are popped in order by reading location 1.
- R4: If location 0 is written while a transfer is running, the running transfer ends with a repeated START instead of STOP. The next transfer then runs with the newly written address byte.
- R5: When the target does not acknowledge a byte the block sent, status bit 6 is set and the transfer is aborted with STOP.
- R6: Status bit 5 is 1 exactly while the receive queue holds data. Status bit 4 is 1 exactly while the transmit queue is empty.
- R7: Status bits 3:2 report the fill of the queue that matches the current direction: 00 empty, 10 for 1 to 3 entries, 11 for 4 entries. The code 01 never appears.
- R8: A cycle that both writes and reads location 1 sets status bit 1. Neither queue changes in that cycle.
- R9: Writing location 1 while the transmit queue holds 4 entries sets status bit 0, and the byte is discarded.
- R10: Writing location 3 with bit 7 set empties the transmit queue.
- R11: Writing location 3 clears each of status bits 6, 1 and 0 whose written bit is 0, and leaves set those whose written bit is 1.
- R12: Status bit 7 is high from START until STOP completes. Inside byte frames, SDA changes only while SCL is low. After reset, both lines are released and status reads 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops the receive queue at location 1) |
| host_addr | input | 2 | Location: 0 address, 1 data, 2 read length, 3 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the addressed location |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
If a queue pointer or count is wrong, the error shows up at the ports either in the status byte on the very next host read, or as wrong or reordered bytes in the target's log once the following transfer finishes. If the bit sequencer is in the wrong state, SDA moves while SCL is high or an acknowledge slot lands on the wrong clock. The bench's target model then misses or misreads the frame, so the error shows within one byte time, about 144 cycles at the default divider. A wrong chaining or abort decision changes how many STARTs, repeated STARTs and STOPs the target model counts for that transfer.

// File: rtl/i2cm_pkg.sv
// Shared definitions for the I2C bus master: register locations, status
// bit positions, sequencer phases and the queue fill code.
package i2cm_pkg;

    localparam logic [1:0] LOC_ADDR  = 2'd0;
    localparam logic [1:0] LOC_DATA  = 2'd1;
    localparam logic [1:0] LOC_COUNT = 2'd2;
    localparam logic [1:0] LOC_STAT  = 2'd3;

    localparam int SB_BUSY  = 7;   // read: busy; write: flush transmit queue
    localparam int SB_NACK  = 6;
    localparam int SB_RXNE  = 5;
    localparam int SB_TXE   = 4;
    localparam int SB_ACCE  = 1;
    localparam int SB_FULLE = 0;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_BIT   = 2'd2,
        PH_STOP  = 2'd3
    } phase_t;

    // Fill code: 00 empty, 10 partly filled, 11 full; 01 unused.
    function automatic logic [1:0] fill_code(input int unsigned fill,
                                             input int unsigned depth);
        if (fill == 0)          return 2'b00;
        else if (fill >= depth) return 2'b11;
        else                    return 2'b10;
    endfunction

endpackage

// File: rtl/i2cm_fifo.sv
// Small first-in first-out queue with show-ahead output.
// Assumes: a push when full and a pop when empty are ignored; flush wins
// over both and empties the queue in one cycle.
module i2cm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          full;
    logic          do_push;
    logic          do_pop;

    // Qualify requests against the present fill.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        rdata   = mem[rd_ptr];
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and fill bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // A rejected push leaves the fill unchanged.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));

    // A pop on an empty queue keeps it empty.
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/i2cm_engine.sv
// Bit and byte sequencer for the I2C master.
// Each SCL period is four quarters of QDIV cycles: q0 low (SDA set),
// q1 and q2 high (sample at the end of q1), q3 low. Holds the current and
// the pending address byte and decides between STOP and repeated START.
// Assumes: single master, no clock stretching, QDIV >= 2.
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int QDIV  = 4,
    parameter int CNT_W = 8,
    localparam int DW   = $clog2(QDIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adr_wr,
    input  logic [7:0]       adr_val,
    input  logic [CNT_W-1:0] rd_count,
    input  logic             tx_empty,
    input  logic [7:0]       tx_head,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_byte,
    input  logic             sda_in,
    output logic             scl_low,
    output logic             sda_low,
    output logic             busy,
    output logic             dir_rd,
    output logic             nack_pulse
);

    phase_t           phase;
    logic [1:0]       q;
    logic [3:0]       bidx;
    logic [7:0]       shreg;
    logic             addr_byte;
    logic             rx_mode;
    logic             ackbit;
    logic             rep;
    logic             chain;
    logic [7:0]       cur_addr;
    logic [7:0]       pend_addr;
    logic [CNT_W-1:0] left;
    logic [DW-1:0]    divcnt;

    logic tick, ack_end, tx_done, go_read, go_write, rx_more, finish;

    // Quarter-phase divider, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || phase == PH_IDLE) divcnt <= '0;
        else if (tick)                  divcnt <= '0;
        else                            divcnt <= divcnt + DW'(1);
    end

    // Decisions taken at the end of an acknowledge clock.
    always_comb begin
        tick       = (divcnt == DW'(QDIV - 1));
        ack_end    = tick && phase == PH_BIT && q == 2'd3 && bidx == 4'd8;
        tx_done    = ack_end && !rx_mode;
        nack_pulse = tx_done && ackbit;
        go_read    = tx_done && !ackbit && addr_byte && cur_addr[0];
        go_write   = tx_done && !ackbit && !(addr_byte && cur_addr[0]) && !tx_empty;
        rx_more    = ack_end && rx_mode && left != CNT_W'(1);
        finish     = (tx_done && !ackbit && !go_read && !go_write) ||
                     (ack_end && rx_mode && left == CNT_W'(1));
        tx_pop     = go_write;
        rx_push    = tick && phase == PH_BIT && q == 2'd1 && rx_mode && bidx == 4'd7;
        rx_byte    = {shreg[6:0], sda_in};
        busy       = (phase != PH_IDLE);
        dir_rd     = cur_addr[0];
    end

    // Line drive derived from phase, quarter and bit slot.
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        case (phase)
            PH_START: begin
                scl_low = (q == 2'd0 && rep) || q == 2'd3;
                sda_low = q[1];
            end
            PH_BIT: begin
                scl_low = (q == 2'd0) || (q == 2'd3);
                if (bidx != 4'd8) sda_low = !rx_mode && !shreg[7];
                else              sda_low = rx_mode && left != CNT_W'(1);
            end
            PH_STOP: begin
                scl_low = (q == 2'd0);
                sda_low = !q[1];
            end
            default: ;
        endcase
    end

    // Sequencer state, address chaining and byte shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            q         <= 2'd0;
            bidx      <= 4'd0;
            shreg     <= 8'd0;
            addr_byte <= 1'b0;
            rx_mode   <= 1'b0;
            ackbit    <= 1'b0;
            rep       <= 1'b0;
            chain     <= 1'b0;
            cur_addr  <= 8'd0;
            pend_addr <= 8'd0;
            left      <= '0;
        end else begin
            if (tick && phase != PH_IDLE) begin
                q <= q + 2'd1;
                case (phase)
                    PH_START: if (q == 2'd3) begin
                        phase     <= PH_BIT;
                        bidx      <= 4'd0;
                        shreg     <= cur_addr;
                        addr_byte <= 1'b1;
                        rx_mode   <= 1'b0;
                    end
                    PH_BIT: begin
                        if (q == 2'd1) begin
                            if (bidx != 4'd8 && rx_mode) shreg <= {shreg[6:0], sda_in};
                            if (bidx == 4'd8 && !rx_mode) ackbit <= sda_in;
                        end
                        if (q == 2'd3) begin
                            if (bidx != 4'd8) begin
                                bidx <= bidx + 4'd1;
                                if (!rx_mode) shreg <= {shreg[6:0], 1'b0};
                            end else begin
                                bidx      <= 4'd0;
                                addr_byte <= 1'b0;
                                if (nack_pulse) begin
                                    phase <= PH_STOP;
                                    chain <= 1'b0;
                                end else if (go_read) begin
                                    rx_mode <= 1'b1;
                                    left    <= (rd_count == '0) ? CNT_W'(1) : rd_count;
                                end else if (go_write) begin
                                    rx_mode <= 1'b0;
                                    shreg   <= tx_head;
                                end else if (rx_more) begin
                                    left <= left - CNT_W'(1);
                                end else if (chain) begin
                                    phase    <= PH_START;
                                    rep      <= 1'b1;
                                    cur_addr <= pend_addr;
                                    chain    <= 1'b0;
                                end else begin
                                    phase <= PH_STOP;
                                end
                            end
                        end
                    end
                    PH_STOP: if (q == 2'd3) begin
                        if (chain) begin
                            phase    <= PH_START;
                            rep      <= 1'b0;
                            cur_addr <= pend_addr;
                            chain    <= 1'b0;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
            if (adr_wr) begin
                if (phase == PH_IDLE) begin
                    cur_addr <= adr_val;
                    phase    <= PH_START;
                    q        <= 2'd0;
                    rep      <= 1'b0;
                end else begin
                    pend_addr <= adr_val;
                    chain     <= 1'b1;
                end
            end
        end
    end

    // Data only moves while the clock is low inside a byte frame.
    assert_sda_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BIT && $past(phase) == PH_BIT && !scl_low) |-> $stable(sda_low));

    // A missing acknowledge leads straight into STOP.
    assert_nack_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nack_pulse |=> (phase == PH_STOP));

    // A pending chain turns the end of a transfer into a repeated START.
    assert_chain_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && chain && !adr_wr) |=> (phase == PH_START && scl_low));

    // The last read byte is followed by STOP unless chained.
    assert_last_read_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_end && rx_mode && left == CNT_W'(1) && !chain && !adr_wr) |=> (phase == PH_STOP));

endmodule

// File: rtl/i2c_fifo_master.sv
// Top of the I2C master: host register port, the two queues, sticky status
// flags and the sequencer. Assumes the host holds host_addr steady with its
// strobes; the data location is read through show-ahead queue output.
module i2c_fifo_master
    import i2cm_pkg::*;
#(
    parameter int QDIV       = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 8,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low
);

    logic             data_wr, data_rd, stat_wr, flush;
    logic             tx_push, rx_pop, tx_full;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic [CW-1:0]    tx_count, rx_count;
    logic             tx_empty, rx_empty, tx_pop, rx_push;
    logic             busy, dir_rd, nack_pulse;
    logic             f_nack, f_acc, f_full;
    logic [7:0]       adr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       lvl;
    logic [7:0]       status;

    // Host strobe decode and conflict screening.
    always_comb begin
        data_wr = host_wr && host_addr == LOC_DATA;
        data_rd = host_rd && host_addr == LOC_DATA;
        stat_wr = host_wr && host_addr == LOC_STAT;
        flush   = stat_wr && host_wdata[SB_BUSY];
        tx_full = (tx_count == CW'(FIFO_DEPTH));
        tx_push = data_wr && !data_rd && !tx_full;
        rx_pop  = data_rd && !data_wr;
    end

    i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) i_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(tx_push), .wdata(host_wdata), .pop(tx_pop),
        .rdata(tx_head), .count(tx_count), .empty(tx_empty)
    );

    i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) i_rxq (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push(rx_push), .wdata(rx_byte), .pop(rx_pop),
        .rdata(rx_head), .count(rx_count), .empty(rx_empty)
    );

    i2cm_engine #(.QDIV(QDIV), .CNT_W(CNT_W)) i_seq (
        .clk(clk), .rst_n(rst_n),
        .adr_wr(host_wr && host_addr == LOC_ADDR), .adr_val(host_wdata),
        .rd_count(cnt_q),
        .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .sda_in(sda_in), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
        .busy(busy), .dir_rd(dir_rd), .nack_pulse(nack_pulse)
    );

    // Plain holding registers for address readback and read length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q <= 8'd0;
            cnt_q <= '0;
        end else begin
            if (host_wr && host_addr == LOC_ADDR)  adr_q <= host_wdata;
            if (host_wr && host_addr == LOC_COUNT) cnt_q <= CNT_W'(host_wdata);
        end
    end

    // Sticky flags: cleared by writing 0, set events win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_nack <= 1'b0;
            f_acc  <= 1'b0;
            f_full <= 1'b0;
        end else begin
            if (stat_wr) begin
                if (!host_wdata[SB_NACK])  f_nack <= 1'b0;
                if (!host_wdata[SB_ACCE])  f_acc  <= 1'b0;
                if (!host_wdata[SB_FULLE]) f_full <= 1'b0;
            end
            if (nack_pulse)                     f_nack <= 1'b1;
            if (data_wr && data_rd)             f_acc  <= 1'b1;
            if (data_wr && !data_rd && tx_full) f_full <= 1'b1;
        end
    end

    // Status assembly and read data selection.
    always_comb begin
        lvl = fill_code(32'(dir_rd ? rx_count : tx_count), FIFO_DEPTH);
        status = {busy, f_nack, !rx_empty, tx_empty, lvl, f_acc, f_full};
        case (host_addr)
            LOC_ADDR:  host_rdata = adr_q;
            LOC_DATA:  host_rdata = rx_head;
            LOC_COUNT: host_rdata = 8'(cnt_q);
            default:   host_rdata = status;
        endcase
    end

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> tx_empty);

    assert_conflict_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && data_rd) |=> (f_acc && $stable(rx_count)));

    assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lvl != 2'b01);

    assert_nack_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nack_pulse |=> f_nack);

    assert_busy_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> busy);

endmodule

// File: tb/test_i2c_fifo_master.sv
module test_i2c_fifo_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       sda_in;
    logic       scl_drive_low;
    logic       sda_drive_low;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    i2c_fifo_master i_i2c_fifo_master (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sda_in(sda_in), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    // ---------------- target model ----------------
    localparam logic [6:0] TGT = 7'h2A;
    logic       slv_low = 1'b0;
    wire        scl_line = ~scl_drive_low;
    wire        sda_line = ~(sda_drive_low | slv_low);
    assign sda_in = sda_line;

    logic scl_p = 1'b1, sda_p = 1'b1;
    bit   s_act, s_addr, s_match, s_tx, s_rw, m_ack;
    int   s_bits;
    logic [7:0] s_sh;
    int   n_start = 0, n_stop = 0, n_rep = 0, wr_n = 0, rd_k = 0, m_nacks = 0;
    logic [7:0] wr_log [64];

    function automatic logic [7:0] rd_val(input int k);
        return 8'((k * 53 + 17) & 255);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            s_act = 0; slv_low = 0; s_bits = 0;
        end else if (scl_line && scl_p && sda_p && !sda_line) begin
            n_start++;
            if (s_act) n_rep++;
            s_act = 1; s_addr = 1; s_tx = 0; s_bits = -1; slv_low = 0;
        end else if (scl_line && scl_p && !sda_p && sda_line) begin
            n_stop++;
            s_act = 0; slv_low = 0;
        end else if (s_act && scl_line && !scl_p) begin
            if (s_bits >= 0 && s_bits < 8 && !s_tx) s_sh = {s_sh[6:0], sda_line};
            if (s_bits == 8 && s_tx) m_ack = !sda_line;
        end else if (s_act && !scl_line && scl_p) begin
            if (s_bits < 7) begin
                s_bits++;
                if (s_tx && s_bits > 0) begin
                    s_sh = {s_sh[6:0], 1'b0};
                    slv_low = !s_sh[7];
                end
            end else if (s_bits == 7) begin
                s_bits = 8;
                if (!s_tx) begin
                    if (s_addr) begin
                        s_match = (s_sh[7:1] == TGT);
                        s_rw = s_sh[0];
                        slv_low = s_match;
                    end else begin
                        if (wr_n < 64) wr_log[wr_n] = s_sh;
                        wr_n++;
                        slv_low = 1;
                    end
                end else slv_low = 0;
            end else begin
                s_bits = 0;
                if (s_addr) begin
                    s_addr = 0;
                    if (!s_match) begin s_act = 0; slv_low = 0; end
                    else if (s_rw) begin
                        s_tx = 1; s_sh = rd_val(rd_k); rd_k++; slv_low = !s_sh[7];
                    end else slv_low = 0;
                end else if (s_tx) begin
                    if (m_ack) begin
                        s_sh = rd_val(rd_k); rd_k++; slv_low = !s_sh[7];
                    end else begin
                        s_tx = 0; slv_low = 0; m_nacks++;
                    end
                end else slv_low = 0;
            end
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hr(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = (a == 2'd1); host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int n = 0;
        do begin
            hr(2'd3, s);
            n++;
        end while (s[7] && n < 20000);
    endtask

    function automatic logic [7:0] code_of(input int n);
        if (n == 0) return 8'h00;
        if (n >= 4) return 8'h0C;
        return 8'h08;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, d;
        logic [7:0] exp_w [4];
        int base_w, base_stop, base_rep, base_nack, exp_k, len;
        int unsigned seed_init;
        seed_init = $urandom(32'd4242);
        exp_k = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12 reset state
        hr(2'd3, s);
        chk("R12 reset status", s, 8'h10);
        chk("R12 reset lines", {scl_drive_low, sda_drive_low}, 2'b00);

        // R7, R9: fill, overflow, then write transfer carries first four
        hw(2'd1, 8'hA1);
        hr(2'd3, s); chk("R7 one entry code / R6 txe low", s, 8'h08);
        hw(2'd1, 8'h5B); hw(2'd1, 8'h00); hw(2'd1, 8'hFF);
        hr(2'd3, s); chk("R7 full code", s, 8'h0C);
        hw(2'd1, 8'h77);
        hr(2'd3, s); chk("R9 overflow flag", s, 8'h0D);
        base_w = wr_n; base_stop = n_stop;
        hw(2'd0, {TGT, 1'b0});
        repeat (3) @(negedge clk);
        hr(2'd3, s); chk("R12 busy during transfer", s[7], 1'b1);
        wait_idle();
        chk("R1 R2 bytes written", wr_n - base_w, 4);
        chk("R2 byte0", wr_log[base_w], 8'hA1);
        chk("R2 byte1", wr_log[base_w+1], 8'h5B);
        chk("R2 byte2", wr_log[base_w+2], 8'h00);
        chk("R9 discarded byte absent", wr_log[base_w+3], 8'hFF);
        chk("R2 one stop", n_stop - base_stop, 1);
        hr(2'd3, s); chk("R6 status after write", s, 8'h11);
        hw(2'd3, 8'h00);
        hr(2'd3, s); chk("R11 clear by zero", s, 8'h10);

        // R8, R10, R11
        repeat (5) hw(2'd1, 8'h3C);
        @(negedge clk);
        host_wr = 1; host_rd = 1; host_addr = 2'd1; host_wdata = 8'h99;
        @(negedge clk);
        host_wr = 0; host_rd = 0;
        hr(2'd3, s); chk("R8 conflict flag, no queue change", s, 8'h0F);
        hw(2'd3, 8'h01);
        hr(2'd3, s); chk("R11 one keeps, zero clears", s, 8'h0D);
        hw(2'd3, 8'h80);
        hr(2'd3, s); chk("R10 flush empties", s, 8'h10);

        // R5: wrong target address
        hw(2'd1, 8'h42);
        base_w = wr_n; base_stop = n_stop;
        hw(2'd0, {7'h11, 1'b0});
        wait_idle();
        hr(2'd3, s); chk("R5 nack flag", s, 8'h48);
        chk("R5 stop after abort", n_stop - base_stop, 1);
        chk("R5 nothing written", wr_n - base_w, 0);
        hw(2'd3, 8'h80);
        hr(2'd3, s); chk("R11 nack cleared", s, 8'h10);

        // R3: read of three, of four, of zero (one)
        foreach (exp_w[i]) exp_w[i] = 8'h00;
        for (int t = 0; t < 3; t++) begin
            int n = (t == 0) ? 3 : (t == 1) ? 4 : 0;
            int got = (n == 0) ? 1 : n;
            base_nack = m_nacks; base_stop = n_stop;
            hw(2'd2, 8'(n));
            hw(2'd0, {TGT, 1'b1});
            wait_idle();
            hr(2'd3, s); chk("R3 R6 R7 status after read", s, 8'h30 | code_of(got));
            chk("R3 single final nack", m_nacks - base_nack, 1);
            chk("R3 stop", n_stop - base_stop, 1);
            for (int i = 0; i < got; i++) begin
                hr(2'd1, d);
                chk("R3 read byte", d, rd_val(exp_k));
                exp_k++;
            end
            hr(2'd3, s); chk("R6 rx drained", s, 8'h10);
        end

        // R4: write two, chain a read of two
        base_w = wr_n; base_stop = n_stop; base_rep = n_rep;
        hw(2'd1, 8'hC3); hw(2'd1, 8'h18);
        hw(2'd2, 8'd2);
        hw(2'd0, {TGT, 1'b0});
        repeat (40) @(negedge clk);
        hw(2'd0, {TGT, 1'b1});
        wait_idle();
        chk("R4 repeated start", n_rep - base_rep, 1);
        chk("R4 single stop", n_stop - base_stop, 1);
        chk("R4 written", wr_n - base_w, 2);
        chk("R4 w0", wr_log[base_w], 8'hC3);
        chk("R4 w1", wr_log[base_w+1], 8'h18);
        hr(2'd3, s); chk("R4 read side status", s, 8'h38);
        for (int i = 0; i < 2; i++) begin
            hr(2'd1, d);
            chk("R4 chained read byte", d, rd_val(exp_k));
            exp_k++;
        end

        // Random transfers
        for (int it = 0; it < 8; it++) begin
            bit rd = 1'($urandom % 2);
            len = 1 + int'($urandom % 4);
            base_stop = n_stop;
            if (rd) begin
                hw(2'd2, 8'(len));
                hw(2'd0, {TGT, 1'b1});
                wait_idle();
                hr(2'd3, s); chk("R3 R7 random read status", s, 8'h30 | code_of(len));
                for (int i = 0; i < len; i++) begin
                    hr(2'd1, d);
                    chk("R3 random read byte", d, rd_val(exp_k));
                    exp_k++;
                end
            end else begin
                base_w = wr_n;
                for (int i = 0; i < len; i++) begin
                    exp_w[i] = 8'($urandom);
                    hw(2'd1, exp_w[i]);
                end
                hw(2'd0, {TGT, 1'b0});
                wait_idle();
                chk("R2 random count", wr_n - base_w, len);
                for (int i = 0; i < len; i++)
                    chk("R2 random byte", wr_log[base_w+i], exp_w[i]);
                hr(2'd3, s); chk("R6 random write status", s, 8'h10);
            end
            chk("R12 stop completes", n_stop - base_stop, 1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule